// File: doc/BRIEF.md
# Trigger Busy and Dead-Time Controller

This block stands between a trigger source and a readout chain. It decides whether each incoming trigger may start an acquisition. The raw trigger arrives asynchronously. It passes through a synchroniser and an edge detector, so each rising edge becomes one event. An event that finds the block idle produces a one-cycle readout-start pulse and makes the block busy. Later events are rejected until the busy period ends.

The busy period can end in two ways. With a non-zero programmed length, it ends after that many clock cycles. With a length of zero, it ends only when the processing side returns a ready pulse. A ready pulse clears busy in either case. A full flag from the downstream buffer also raises busy directly.

A mode input selects how rejected triggers behave. In fixed mode they leave the running dead time alone. In retrigger mode each of them reloads it, so a dense trigger stream keeps the block busy indefinitely. Two saturating counters record accepted and rejected events, which gives the acquisition efficiency.

Top module: `trgc_busy_ctrl`

## Requirements
- R1: A start pulse on `accept_o` occurs only in a cycle where `busy_o` is low. It occurs for every trigger event that finds the block idle with no ready pulse in that cycle.
- R2: `accept_o` lasts exactly one cycle. `busy_o` is high in the cycle after it.
- R3: A cycle with `ready_i` high clears the internal dead-time state. From the next cycle `busy_o` follows only `buf_full_i`, until a new acceptance.
- R4: When a trigger event and `ready_i` fall in the same cycle, the event is deferred by one cycle. It is then judged again only if the synchronised trigger level is still high. If the level has gone low, the event is counted as rejected.
- R5: With `retrig_mode_i` = 0 and `dead_len_i` = L > 0, busy from an acceptance lasts exactly L cycles. Triggers in that window are rejected and do not lengthen it.
- R6: With `retrig_mode_i` = 1 and L > 0, a trigger event during the dead time reloads the count to L. Busy ends L cycles after the last such event.
- R7: With `dead_len_i` = 0, busy from an acceptance persists until `ready_i`.
- R8: `buf_full_i` high forces `busy_o` high in the same cycle. Any trigger event in that cycle is counted as rejected. While no dead time is running, it does not start one.
- R9: The trigger input passes through two flops. A rising edge sampled at clock edge k gives its event in the cycle that follows edge k+1. A held level yields a single event.
- R10: `acc_count_o` counts accepted events. `rej_count_o` counts events rejected because of busy, including deferred events that vanished.
- R11: Both counters stop at their all-ones value and hold it.
- R12: Reset clears busy, the dead-time timer, any deferred event and both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_async_i | input | 1 | Raw trigger level, asynchronous |
| ready_i | input | 1 | Ready pulse from the processing side |
| buf_full_i | input | 1 | Downstream buffer full |
| retrig_mode_i | input | 1 | 0 fixed dead time, 1 retriggerable dead time |
| dead_len_i | input | LEN_W (16) | Dead-time length in cycles, 0 for handshake only |
| accept_o | output | 1 | One-cycle readout start |
| busy_o | output | 1 | Busy level |
| acc_count_o | output | CNT_W (32) | Accepted event count |
| rej_count_o | output | CNT_W (32) | Rejected event count |

## Verification
The properties assume that `buf_full_i`, `ready_i`, `retrig_mode_i` and `dead_len_i` are synchronous to `clk`. The countdown properties also assume that `dead_len_i` does not change while a dead time is running. The stimulus drives all of these on the falling edge. It changes the mode and the length only after busy has dropped. Only the trigger is treated as asynchronous, and it is still driven on the falling edge so that the synchroniser timing is deterministic.

// File: rtl/trgc_pkg.sv
`timescale 1ns/1ps
package trgc_pkg;
   // dead-time behaviour selected by the mode input
   typedef enum logic {
      DT_FIXED   = 1'b0,
      DT_RETRIG  = 1'b1
   } dt_mode_e;

   localparam int unsigned SYNC_MIN_STAGES = 2;
endpackage

// File: rtl/trgc_sync.sv
`timescale 1ns/1ps
module trgc_sync
   import trgc_pkg::*;
#(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level_o,
   output logic rise_o
);
   generate
      if (STAGES < SYNC_MIN_STAGES) begin : g_bad_stages
         $error("trgc_sync: STAGES below minimum");
      end
   endgenerate

   // chain[STAGES-1] is the synchronised level, chain[STAGES] its history
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], din};
   end

   assign level_o = chain[STAGES-1];
   assign rise_o  = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/trgc_dead_timer.sv
`timescale 1ns/1ps
module trgc_dead_timer #(
   parameter int unsigned LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             load_i,
   input  logic             restart_i,
   input  logic [LEN_W-1:0] len_i,
   output logic             active_o,
   output logic [LEN_W-1:0] count_o
);
   generate
      if (LEN_W < 1) begin : g_bad_len
         $error("trgc_dead_timer: LEN_W must be positive");
      end
   endgenerate

   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   logic             active_q;
   logic [LEN_W-1:0] cnt_q;
   logic             timed;

   assign timed = |len_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (clear_i) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (load_i) begin
         active_q <= 1'b1;
         cnt_q    <= len_i;
      end else if (restart_i && timed) begin
         cnt_q    <= len_i;
      end else if (cnt_q != '0) begin
         cnt_q    <= cnt_q - ONE;
         if (cnt_q == ONE) active_q <= 1'b0;
      end
   end

   assign active_o = active_q;
   assign count_o  = cnt_q;
endmodule

// File: rtl/trgc_sat_cnt.sv
`timescale 1ns/1ps
module trgc_sat_cnt #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   output logic [W-1:0] count_o
);
   generate
      if (W < 2) begin : g_bad_w
         $error("trgc_sat_cnt: W must be at least 2");
      end
   endgenerate

   localparam logic [W-1:0] TOP = {W{1'b1}};

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (inc_i && cnt_q != TOP) cnt_q <= cnt_q + W'(1);
   end

   assign count_o = cnt_q;
endmodule

// File: rtl/trgc_busy_ctrl.sv
`timescale 1ns/1ps
module trgc_busy_ctrl
   import trgc_pkg::*;
#(
   parameter int unsigned LEN_W       = 16,
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_async_i,
   input  logic             ready_i,
   input  logic             buf_full_i,
   input  logic             retrig_mode_i,
   input  logic [LEN_W-1:0] dead_len_i,
   output logic             accept_o,
   output logic             busy_o,
   output logic [CNT_W-1:0] acc_count_o,
   output logic [CNT_W-1:0] rej_count_o
);
   localparam int unsigned N_CNT = 2;

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("trgc_busy_ctrl: CNT_W must be at least 2");
      end
   endgenerate

   dt_mode_e         mode;
   logic             trig_level;
   logic             trig_rise;
   logic             defer_q;
   logic             trig_evt;
   logic             defer_lost;
   logic             evt_live;
   logic             dt_active;
   logic [LEN_W-1:0] dt_count;
   logic             busy_int;
   logic             take;
   logic             refuse;
   logic             reload;
   logic [N_CNT-1:0] cnt_inc;
   logic [CNT_W-1:0] cnt_val [N_CNT];

   assign mode = dt_mode_e'(retrig_mode_i);

   trgc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (trig_async_i),
      .level_o (trig_level),
      .rise_o  (trig_rise)
   );

   // event is fresh edge, or a deferred one whose level persists
   assign trig_evt   = trig_rise | (defer_q & trig_level);
   assign defer_lost = defer_q & ~trig_level;
   assign evt_live   = trig_evt & ~ready_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) defer_q <= 1'b0;
      else        defer_q <= trig_evt & ready_i;
   end

   assign busy_int = dt_active | buf_full_i;
   assign take     = evt_live & ~busy_int;
   assign refuse   = (evt_live & busy_int) | defer_lost;
   assign reload   = evt_live & dt_active & (mode == DT_RETRIG);

   trgc_dead_timer #(.LEN_W(LEN_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (ready_i),
      .load_i    (take),
      .restart_i (reload),
      .len_i     (dead_len_i),
      .active_o  (dt_active),
      .count_o   (dt_count)
   );

   assign cnt_inc = {refuse, take};

   generate
      for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
         trgc_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc_i   (cnt_inc[g]),
            .count_o (cnt_val[g])
         );
      end
   endgenerate

   assign accept_o    = take;
   assign busy_o      = busy_int;
   assign acc_count_o = cnt_val[0];
   assign rej_count_o = cnt_val[1];
endmodule

// File: rtl/trgc_busy_ctrl_chk.sv
`timescale 1ns/1ps
module trgc_busy_ctrl_chk #(
   parameter int unsigned LEN_W = 16,
   parameter int unsigned CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ready_i,
   input logic             buf_full_i,
   input logic             retrig_mode_i,
   input logic             accept_o,
   input logic             busy_o,
   input logic [CNT_W-1:0] acc_count_o,
   input logic             dt_active,
   input logic [LEN_W-1:0] dt_count
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   p_accept_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      accept_o |-> !busy_o);

   p_busy_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      accept_o |=> busy_o && !accept_o);

   p_ready_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ready_i |=> !dt_active);

   p_fixed_countdown_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dt_active && !ready_i && !retrig_mode_i && dt_count != '0)
      |=> dt_count == LEN_W'($past(dt_count) - LEN_W'(1)));

   p_fixed_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dt_active && !ready_i && !retrig_mode_i && dt_count == LEN_W'(1))
      |=> !dt_active);

   p_handshake_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dt_active && !ready_i && dt_count == '0) |=> dt_active);

   p_full_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      buf_full_i |-> busy_o && !accept_o);

   p_acc_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_o && acc_count_o != CMAX)
      |=> acc_count_o == CNT_W'($past(acc_count_o) + CNT_W'(1)));

   p_acc_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      acc_count_o == CMAX |=> acc_count_o == CMAX);
endmodule

bind trgc_busy_ctrl trgc_busy_ctrl_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ready_i       (ready_i),
   .buf_full_i    (buf_full_i),
   .retrig_mode_i (retrig_mode_i),
   .accept_o      (accept_o),
   .busy_o        (busy_o),
   .acc_count_o   (acc_count_o),
   .dt_active     (dt_active),
   .dt_count      (dt_count)
);

// File: tb/trgc_busy_ctrl_tb.sv
`timescale 1ns/1ps
module trgc_busy_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trig = 1'b0;
   logic        rdy = 1'b0;
   logic        full = 1'b0;
   logic        mode = 1'b0;
   logic [15:0] len = 16'd0;

   logic        acc_o, busy_o, s_acc_o, s_busy_o;
   logic [31:0] acc_cnt, rej_cnt;
   logic [2:0]  s_acc_cnt, s_rej_cnt;

   always #2 clk = ~clk;   // 250 MHz

   trgc_busy_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .trig_async_i(trig), .ready_i(rdy),
      .buf_full_i(full), .retrig_mode_i(mode), .dead_len_i(len),
      .accept_o(acc_o), .busy_o(busy_o),
      .acc_count_o(acc_cnt), .rej_count_o(rej_cnt)
   );

   trgc_busy_ctrl #(.CNT_W(3)) u_dut_sat (
      .clk(clk), .rst_n(rst_n), .trig_async_i(trig), .ready_i(rdy),
      .buf_full_i(full), .retrig_mode_i(mode), .dead_len_i(len),
      .accept_o(s_acc_o), .busy_o(s_busy_o),
      .acc_count_o(s_acc_cnt), .rej_count_o(s_rej_cnt)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done = 0;
   string cur_req = "R12";

   // behavioural reference state
   bit     m_h1, m_h2, m_h3, m_def, m_busy;
   int     m_left;
   longint m_acc, m_rej;

   function automatic bit m_event();
      return (m_h2 && !m_h3) || (m_def && m_h2);
   endfunction
   function automatic bit m_accept();
      return m_event() && !rdy && !(m_busy || full);
   endfunction
   function automatic bit m_reject();
      return (m_event() && !rdy && (m_busy || full)) || (m_def && !m_h2);
   endfunction

   always @(posedge clk) begin
      if (rst_n) begin
         bit e, a, r;
         e = m_event();
         a = m_accept();
         r = m_reject();
         if (a) m_acc++;
         if (r) m_rej++;
         if (rdy) begin
            m_busy = 0; m_left = 0;
         end else if (a) begin
            m_busy = 1; m_left = len;
         end else if (e && m_busy && mode && len != 0) begin
            m_left = len;
         end else if (m_left != 0) begin
            if (m_left == 1) m_busy = 0;
            m_left--;
         end
         m_def = e && rdy;
         m_h3 = m_h2; m_h2 = m_h1; m_h1 = trig;
      end
   end

   task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
      end
   endtask

   task automatic compare();
      longint sa, sr;
      sa = (m_acc > 7) ? 7 : m_acc;
      sr = (m_rej > 7) ? 7 : m_rej;
      chk("accept", acc_o, rst_n ? m_accept() : 1'b0);
      chk("busy", busy_o, m_busy || full);
      chk("acc_count R10", acc_cnt, m_acc);
      chk("rej_count R10", rej_cnt, m_rej);
      chk("sat acc_count R11", s_acc_cnt, sa);
      chk("sat rej_count R11", s_rej_cnt, sr);
   endtask

   task automatic cyc(bit t, bit r, bit f);
      @(negedge clk);
      trig = t; rdy = r; full = f;
      #1;
      compare();
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0);
   endtask

   task automatic pulse(int hi, int lo);
      for (int i = 0; i < hi; i++) cyc(1, 0, 0);
      for (int i = 0; i < lo; i++) cyc(0, 0, 0);
   endtask

   task automatic m_clear();
      m_h1 = 0; m_h2 = 0; m_h3 = 0; m_def = 0; m_busy = 0;
      m_left = 0; m_acc = 0; m_rej = 0;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #800000;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL R12 watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      m_clear();
      // R12: reset state
      cur_req = "R12";
      for (int i = 0; i < 3; i++) cyc(1, 0, 0);
      @(negedge clk); rst_n = 1'b1; trig = 0;
      idle(3);

      // R9: held level gives a single event after two flops; handshake mode
      cur_req = "R9";
      len = 0; mode = 0;
      pulse(6, 4);

      // R7: no timer, busy holds, further triggers rejected
      cur_req = "R7";
      pulse(2, 3);
      pulse(1, 20);

      // R3: ready clears busy
      cur_req = "R3";
      cyc(0, 1, 0);
      idle(4);

      // R5: fixed dead time of 5 cycles
      cur_req = "R5";
      len = 16'd5;
      pulse(1, 2);
      pulse(1, 12);

      // R6: retriggerable dead time of 6 cycles, triggers every 4 cycles
      cur_req = "R6";
      mode = 1; len = 16'd6;
      for (int k = 0; k < 4; k++) pulse(1, 3);
      idle(12);

      // R4: ready coincident with an event, level held -> accepted next cycle
      cur_req = "R4";
      mode = 0; len = 16'd0;
      cyc(1, 0, 0); cyc(1, 0, 0); cyc(1, 1, 0); cyc(1, 0, 0);
      idle(3);
      cyc(0, 1, 0);
      idle(3);
      // R4: level gone -> deferred event counted rejected
      cyc(1, 0, 0); cyc(0, 0, 0); cyc(0, 1, 0); cyc(0, 0, 0);
      idle(4);

      // R8: buffer full blocks; then full during a running retrigger window
      cur_req = "R8";
      cyc(1, 0, 1); cyc(0, 0, 1); cyc(0, 0, 1); cyc(0, 0, 1);
      idle(4);
      mode = 1; len = 16'd4;
      pulse(1, 3);
      cyc(1, 0, 1); cyc(0, 0, 1); cyc(0, 0, 1);
      idle(10);

      // R1 R2 R10: accept then handshake clear, repeated
      cur_req = "R1 R2 R10";
      mode = 0; len = 16'd0;
      for (int k = 0; k < 3; k++) begin
         pulse(1, 4);
         cyc(0, 1, 0);
         idle(2);
      end

      // R11: enough accepts to saturate the narrow counters
      cur_req = "R11";
      len = 16'd2;
      for (int k = 0; k < 10; k++) pulse(1, 4);
      for (int k = 0; k < 4; k++) pulse(1, 0);
      idle(6);

      done = 1;
      summary();
      $finish;
   end
endmodule